// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table stored in memory. The address splits into three fields, from the top down: a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit byte offset (bits 11:0), so pages are 4 KiB.

The walker reads the first-level table, which a table base input locates. That entry names the second-level table. It then reads the second-level entry, which gives the frame, and joins the frame with the offset. If the entry at either level is marked invalid, the walk stops and reports a fault, together with the level that failed.

Requests arrive on a valid/ready channel and results leave on another. The request side asserts `req_ready` only while the walker is idle. A result stays on the output, unchanged, until the consumer takes it with `res_ready`. The single memory read port uses a valid/ready request and then waits any number of cycles for `mem_rsp_valid`. Only one read is outstanding at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, and both `res_valid` and `mem_req_valid` are 0.
- R2: The first memory read goes to `table_base + 4*va[31:22]`, using the base value captured when the request was accepted.
- R3: A first-level entry is valid when its bit 0 is 1. After such an entry, the second read goes to `{entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: A second-level entry is valid when its bit 0 is 1. After such an entry, the result has `res_fault`=0, `res_fault_level`=0 and `res_paddr = {entry[31:12], va[11:0]}`.
- R5: If the first-level entry has bit 0 = 0, the result has `res_fault`=1, `res_fault_level`=1 and `res_paddr`=0, and no second read is issued.
- R6: If the second-level entry has bit 0 = 0, the result has `res_fault`=1, `res_fault_level`=2 and `res_paddr`=0.
- R7: Only one read is outstanding at a time. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` accepts the read. After that, `mem_req_valid` stays 0 until `mem_rsp_valid` returns.
- R8: `req_ready` is 1 only while the walker is idle. A result holds `res_valid` and every result field steady until `res_ready` is seen. In the cycle after that, the walker is idle again.
- R9: After a request is accepted, changes on `req_vaddr` and `table_base` do not affect that walk's read addresses or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and takes the request |
| req_vaddr | input | 32 | Logical address to translate |
| table_base | input | 32 | Byte address of the first-level table, captured on accept |
| mem_req_valid | output | 1 | A table read is being requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Table entry: frame in bits 31:12, valid in bit 0 |
| res_valid | output | 1 | A result is offered |
| res_ready | input | 1 | The consumer takes the result |
| res_paddr | output | 32 | Physical address, or 0 on a fault |
| res_fault | output | 1 | The walk ended on an invalid entry |
| res_fault_level | output | 2 | 1 or 2 for the level that failed, 0 on success |

## Verification
Each result is tied to a known cycle, and the bench samples on falling edges, in the middle of the cycle:

| Rising edge | What appears |
|---|---|
| Request accepted | First read request |
| First read accepted | `mem_req_valid` falls |
| Valid first-level response arrives | Second read request |
| Final response arrives | `res_valid` |
| `res_ready` seen | `req_ready` |

At each of these points the bench checks the port against a value computed by its own functions. It also checks every intervening cycle of memory stall, response latency and result back-pressure, for held or deasserted outputs.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OUTER = 3'd1,
    ST_INNER = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_t;

  localparam int ENTRY_BYTES_LOG2 = 2;
  localparam int VALID_BIT        = 0;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] va,
  output logic [IDX_W-1:0]  top_idx,
  output logic [IDX_W-1:0]  mid_idx,
  output logic [OFF_W-1:0]  pg_off
);
  assign top_idx = va[ADDR_W-1 -: IDX_W];
  assign mid_idx = va[OFF_W +: IDX_W];
  assign pg_off  = va[OFF_W-1:0];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] ent_addr
);
  import pt_walk_pkg::*;
  localparam int PAD_W = ADDR_W - IDX_W - ENTRY_BYTES_LOG2;

  assign ent_addr = tbl_base + {{PAD_W{1'b0}}, idx, {ENTRY_BYTES_LOG2{1'b0}}};
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] entry,
  output logic              ent_ok,
  output logic [ADDR_W-1:0] frame_base
);
  import pt_walk_pkg::*;

  assign ent_ok     = entry[VALID_BIT];
  assign frame_base = {entry[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_paddr,
  output logic              res_fault,
  output logic [1:0]        res_fault_level
);
  import pt_walk_pkg::*;

  localparam int LEVELS = 2;
  localparam int OFF_PAD = ADDR_W - OFF_W;
  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_MID  = 2'd2;

  walk_state_t state_q;
  logic        waiting_q;
  logic [ADDR_W-1:0] va_q;
  logic [LEVELS-1:0][ADDR_W-1:0] tbl_q;
  logic [LEVELS-1:0][IDX_W-1:0]  lvl_idx;
  logic [LEVELS-1:0][ADDR_W-1:0] lvl_addr;
  logic [ADDR_W-1:0] paddr_q;
  logic [1:0]        flvl_q;
  logic [OFF_W-1:0]  pg_off;
  logic              rsp_ok;
  logic [ADDR_W-1:0] rsp_frame;

  pt_va_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .va(va_q), .top_idx(lvl_idx[0]), .mid_idx(lvl_idx[1]), .pg_off(pg_off)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_eaddr (
      .tbl_base(tbl_q[g]), .idx(lvl_idx[g]), .ent_addr(lvl_addr[g])
    );
  end

  pt_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .entry(mem_rsp_data), .ent_ok(rsp_ok), .frame_base(rsp_frame)
  );

  assign req_ready       = (state_q == ST_IDLE);
  assign mem_req_valid   = ((state_q == ST_OUTER) || (state_q == ST_INNER)) && !waiting_q;
  assign mem_req_addr    = (state_q == ST_INNER) ? lvl_addr[1] : lvl_addr[0];
  assign res_valid       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign res_fault       = (state_q == ST_FAULT);
  assign res_paddr       = paddr_q;
  assign res_fault_level = flvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      waiting_q <= 1'b0;
      va_q      <= '0;
      tbl_q     <= '0;
      paddr_q   <= '0;
      flvl_q    <= LVL_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr;
            tbl_q[0]  <= table_base;
            waiting_q <= 1'b0;
            state_q   <= ST_OUTER;
          end
        end
        ST_OUTER, ST_INNER: begin
          if (!waiting_q) begin
            if (mem_req_ready) waiting_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            waiting_q <= 1'b0;
            if (!rsp_ok) begin
              paddr_q <= '0;
              flvl_q  <= (state_q == ST_OUTER) ? LVL_TOP : LVL_MID;
              state_q <= ST_FAULT;
            end else if (state_q == ST_OUTER) begin
              tbl_q[1] <= rsp_frame;
              state_q  <= ST_INNER;
            end else begin
              paddr_q <= rsp_frame | {{OFF_PAD{1'b0}}, pg_off};
              flvl_q  <= LVL_NONE;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  assert_read_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) &&
                                   $stable(res_fault) && $stable(res_fault_level)));

  assert_fault_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> ((res_fault_level == LVL_TOP) || (res_fault_level == LVL_MID)));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> ((res_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]) &&
                                   (res_fault_level == LVL_NONE)));

  assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] table_base = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic res_fault;
  logic [1:0] res_fault_level;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  always #2 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .table_base(table_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_fault_level(res_fault_level)
  );

  function automatic logic [31:0] top_addr(logic [31:0] base, logic [31:0] va);
    return base + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] mid_addr(logic [31:0] ent, logic [31:0] va);
    return {ent[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
  endfunction

  function automatic logic [31:0] phys(logic [31:0] ent, logic [31:0] va);
    return {ent[31:12], va[11:0]};
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic serve(logic [31:0] addr, logic [31:0] data, string rq);
    int stall = int'($urandom % 3);
    int lat = int'($urandom % 4);
    check(rq, {31'd0, mem_req_valid}, 32'd1);
    check(rq, mem_req_addr, addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R7 held", {31'd0, mem_req_valid}, 32'd1);
      check("R7 addr", mem_req_addr, addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      check("R7 wait", {31'd0, mem_req_valid}, 32'd0);
      @(negedge clk);
    end
    check("R7 wait", {31'd0, mem_req_valid}, 32'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = $urandom;
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] base, logic [31:0] oent, logic [31:0] ient);
    logic [31:0] ep;
    logic [1:0] el;
    logic ef;
    int hold = int'($urandom % 3);
    check("R8 idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    table_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    table_base = $urandom;
    check("R8 busy", {31'd0, req_ready}, 32'd0);
    serve(top_addr(base, va), oent, "R2 R9");
    if (oent[0]) serve(mid_addr(oent, va), ient, "R3 R9");
    if (!oent[0]) begin
      ep = 0; ef = 1; el = 2'd1;
      check("R5 no second read", {31'd0, mem_req_valid}, 32'd0);
    end else if (!ient[0]) begin
      ep = 0; ef = 1; el = 2'd2;
    end else begin
      ep = phys(ient, va); ef = 0; el = 2'd0;
    end
    check("R8 res_valid", {31'd0, res_valid}, 32'd1);
    check(ef ? (el == 2'd1 ? "R5 fault" : "R6 fault") : "R4 fault", {31'd0, res_fault}, {31'd0, ef});
    check(ef ? (el == 2'd1 ? "R5 level" : "R6 level") : "R4 level", {30'd0, res_fault_level}, {30'd0, el});
    check(ef ? "R5 R6 paddr" : "R4 R9 paddr", res_paddr, ep);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 hold", {31'd0, res_valid}, 32'd1);
      check("R8 hold paddr", res_paddr, ep);
      check("R8 no accept", {31'd0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R8 released", {31'd0, res_valid}, 32'd0);
    check("R8 idle again", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 res", {31'd0, res_valid}, 32'd0);
    check("R1 mem", {31'd0, mem_req_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", {31'd0, req_ready}, 32'd1);
    check("R1 after", {31'd0, res_valid | mem_req_valid}, 32'd0);
    // directed corner cases
    walk(32'h0000_0000, 32'h0001_0000, 32'h0020_0001, 32'h0ABC_D001);
    walk(32'hFFFF_FFFF, 32'h8000_0004, 32'h1234_5FFF, 32'hFEDC_BFFF);
    walk(32'h1234_5678, 32'h0004_0000, 32'h0030_0FFE, 32'h0000_0001);
    walk(32'h8765_4321, 32'h0004_0000, 32'h0030_0001, 32'h5555_5FFE);
    walk(32'h003F_F123, 32'hFFFF_F000, 32'hFFFF_F001, 32'h0000_0001);
    // constrained random walks
    for (int n = 0; n < 80; n++) begin
      logic [31:0] o = $urandom;
      logic [31:0] i = $urandom;
      o[0] = (($urandom % 8) != 0);
      i[0] = (($urandom % 8) != 0);
      walk($urandom, {$urandom} & 32'hFFFF_FFFC, o, i);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule